// File: doc/BRIEF.md
# Four-Endpoint Synchronous Slave FIFO Port

This block lets an external bus master move data through four packet-oriented endpoint buffers. The buffers share one interface clock, one bidirectional data bus and one set of strobes. A 2-bit endpoint selector picks the buffer that a write, a read, a packet-end strobe and the two status flags refer to. On the write side, bytes or 16-bit words are captured on the clock edge whenever the write strobe is sampled. These bytes stay pending and cannot be read back until the packet holding them is committed.

A packet is committed in one of two ways. The first is the packet-end strobe, which can come with the last write or on any later cycle. The second is automatic: it happens once the pending byte count reaches a per-endpoint length, if automatic mode is enabled for that endpoint. On the read side, the head of the committed data is always shown on the bus while output enable is active, and each sampled read strobe moves to the next byte or word. Each endpoint has its own width bit that selects byte-wide or word-wide transfers. A chip-select input gates every strobe and the bus driver.

Top module: `slave_fifo_port`

## Requirements
- R1: After reset every endpoint holds no data, empty_flag is 1 and full_flag is 0 for any selected endpoint.
- R2: Writes, reads, packet-end and both flags act only on the endpoint selected by ep_sel. Data committed to one endpoint never appears when another is selected.
- R3: Each endpoint stores DEPTH bytes (default 512). full_flag is 1 when a further transfer of the selected width would not fit. A write while full is dropped.
- R4: data_io is driven only while cs and oe are both 1, and is released otherwise.
- R5: While data is committed, data_io shows the oldest unread unit. Each read strobe sampled on a rising edge advances it by one unit. A read while empty_flag is 1 is dropped.
- R6: When cs and wr_stb are 1 and the endpoint is not full, the data on data_io is stored at the rising edge.
- R7: Written data stays invisible to reads until committed: empty_flag remains 1 while only uncommitted data is held.
- R8: With auto_en bit n set, endpoint n commits its pending data on the write that makes the pending byte count reach auto_len[n] (when it is nonzero).
- R9: pkt_end commits all pending data, including a write sampled on the same edge, and it may follow the last write by any number of cycles. pkt_end with nothing pending leaves the endpoint unchanged.
- R10: With wide_cfg bit n set, endpoint n moves 16 bits per strobe. The first unit read is the first word written. In byte mode only data_io[7:0] carries data and data_io[15:8] is not driven.
- R11: While cs is 0, wr_stb, rd_stb and pkt_end have no effect on any endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, gates strobes and bus drive |
| ep_sel | input | 2 | Endpoint selector |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| oe | input | 1 | Output enable for data_io |
| pkt_end | input | 1 | Commit the pending packet of the selected endpoint |
| wide_cfg | input | 4 | Per-endpoint 16-bit mode |
| auto_en | input | 4 | Per-endpoint automatic commit enable |
| auto_len | input | 4x10 | Per-endpoint automatic commit length in bytes |
| data_io | inout | 16 | Shared tri-stated data bus |
| full_flag | output | 1 | Selected endpoint cannot take another unit |
| empty_flag | output | 1 | Selected endpoint has no committed unit to read |

## Verification
On every cycle the assertions check that an endpoint never holds more than its capacity, and that committed data never exceeds what was written. They also check that writes while full and reads while empty leave the pointers untouched, and that word-mode pointers stay even. Only the bench scenarios can show the end-to-end behaviour. This covers data order across a full 512-byte fill, hiding of uncommitted bytes, commit by length versus by strobe (with a zero-length strobe), word ordering, chip-select gating and the bus being released.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int NUM_EP = 4;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 2 * BYTE_W;
  localparam int SEL_W  = $clog2(NUM_EP);
  typedef logic [SEL_W-1:0] ep_sel_t;
  typedef logic [BUS_W-1:0] bus_word_t;
endpackage

// File: rtl/sfifo_bank.sv
module sfifo_bank #(
  parameter int ENTRIES = 256,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_lane.sv
module sfifo_lane #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          commit_req,
  input  logic          wide,
  input  logic          auto_on,
  input  logic [CW-1:0] auto_len,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] wr_ptr, cmt_ptr, rd_ptr;
  logic [CW-1:0] step, level, ready, wr_next;
  logic          do_wr, do_rd, auto_hit;
  logic [1:0][7:0] bank_q;

  assign step    = wide ? CW'(2) : CW'(1);
  assign level   = wr_ptr - rd_ptr;
  assign ready   = cmt_ptr - rd_ptr;
  assign full    = (CW'(DEPTH) - level) < step;
  assign empty   = ready < step;
  assign do_wr   = wr_req & ~full;
  assign do_rd   = rd_req & ~empty;
  assign wr_next = do_wr ? wr_ptr + step : wr_ptr;
  assign auto_hit = auto_on && (auto_len != '0) && ((wr_next - cmt_ptr) >= auto_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      wr_ptr <= wr_next;
      if (commit_req || (do_wr && auto_hit)) cmt_ptr <= wr_next;
      if (do_rd) rd_ptr <= rd_ptr + step;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic       we;
    logic [7:0] wd;
    assign we = do_wr & (wide | (wr_ptr[0] == 1'(b)));
    assign wd = wide ? wr_data[8*b +: 8] : wr_data[7:0];
    sfifo_bank #(.ENTRIES(DEPTH/2)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (wr_ptr[AW-1:1]),
      .wdata (wd),
      .raddr (rd_ptr[AW-1:1]),
      .rdata (bank_q[b])
    );
  end

  assign rd_data = wide ? {bank_q[1], bank_q[0]}
                        : {8'h00, (rd_ptr[0] ? bank_q[1] : bank_q[0])};

  // R3: stored bytes never exceed capacity
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  // R3: a write into a full endpoint leaves the write pointer alone
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full) |=> (wr_ptr == $past(wr_ptr)));
  // R5: a read from an empty endpoint leaves the read pointer alone
  assert_empty_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> (rd_ptr == $past(rd_ptr)));
  // R7: committed data is a subset of written data
  assert_commit_order_R7: assert property (@(posedge clk) disable iff (rst)
    ready <= level);
  // R10: word mode keeps both pointers on even byte positions
  assert_wide_align_R10: assert property (@(posedge clk) disable iff (rst)
    wide |-> (!wr_ptr[0] && !rd_ptr[0]));
endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs,
  input  logic [SEL_W-1:0]          ep_sel,
  input  logic                      wr_stb,
  input  logic                      rd_stb,
  input  logic                      oe,
  input  logic                      pkt_end,
  input  logic [NUM_EP-1:0]         wide_cfg,
  input  logic [NUM_EP-1:0]         auto_en,
  input  logic [NUM_EP-1:0][CW-1:0] auto_len,
  inout  wire  [BUS_W-1:0]          data_io,
  output logic                      full_flag,
  output logic                      empty_flag
);
  logic [NUM_EP-1:0][BUS_W-1:0] lane_rd;
  logic [NUM_EP-1:0]            lane_full, lane_empty;
  bus_word_t                    head;
  logic                         drive;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit;
    assign hit = cs && (ep_sel == ep_sel_t'(e));
    sfifo_lane #(.DEPTH(DEPTH)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .wr_req     (hit & wr_stb),
      .rd_req     (hit & rd_stb),
      .commit_req (hit & pkt_end),
      .wide       (wide_cfg[e]),
      .auto_on    (auto_en[e]),
      .auto_len   (auto_len[e]),
      .wr_data    (data_io),
      .rd_data    (lane_rd[e]),
      .full       (lane_full[e]),
      .empty      (lane_empty[e])
    );
  end

  assign head       = lane_rd[ep_sel];
  assign full_flag  = lane_full[ep_sel];
  assign empty_flag = lane_empty[ep_sel];
  assign drive      = cs & oe;

  assign data_io[BYTE_W-1:0]     = drive ? head[BYTE_W-1:0] : {BYTE_W{1'bz}};
  assign data_io[BUS_W-1:BYTE_W] = (drive && wide_cfg[ep_sel]) ? head[BUS_W-1:BYTE_W]
                                                               : {BYTE_W{1'bz}};
endmodule

// File: tb/test_slave_fifo_port.sv
module test_slave_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int NV = 17;

  // vector: sel[23:22] wr[21] rd[20] pe[19] din[18:11] exp_empty[10] exp_full[9] chk[8] exp_dout[7:0]
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b1, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 8'h11},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22},
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h44, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h44},
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'hA2, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'hA3, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'hA4, 1'b0, 1'b0, 1'b1, 8'hA1},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA2},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA3},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA4},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, oe = 1'b0, pkt_end = 1'b0;
  logic [1:0] ep_sel = 2'd0;
  logic [3:0] wide_cfg = 4'b1000;
  logic [3:0] auto_en  = 4'b0100;
  logic [3:0][CW-1:0] auto_len;
  logic        tb_en = 1'b0;
  logic [15:0] tb_drv = 16'h0000;
  wire  [15:0] data_io;
  logic full_flag, empty_flag;
  int checks = 0;
  int errors = 0;

  assign data_io = tb_en ? tb_drv : 16'hzzzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_fifo_port #(.DEPTH(DEPTH)) i_slave_fifo_port (
    .clk(clk), .rst(rst), .cs(cs), .ep_sel(ep_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .oe(oe), .pkt_end(pkt_end), .wide_cfg(wide_cfg), .auto_en(auto_en),
    .auto_len(auto_len), .data_io(data_io), .full_flag(full_flag), .empty_flag(empty_flag)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one bus operation applied at a falling edge, taking effect at the next rising edge
  task automatic op(input logic [1:0] sel, input logic w, input logic r, input logic p,
                    input logic [15:0] d);
    ep_sel = sel; wr_stb = w; rd_stb = r; pkt_end = p;
    tb_en = w; tb_drv = d;
    tick();
    wr_stb = 1'b0; rd_stb = 1'b0; pkt_end = 1'b0; tb_en = 1'b0;
  endtask

  task automatic peek(output logic [15:0] v);
    oe = 1'b1;
    #1;
    v = data_io;
    oe = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired, run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    auto_len = '0;
    auto_len[2] = CW'(4);
    tick(); tick();
    rst = 1'b0;
    cs = 1'b1;

    // R1: reset state on every endpoint
    for (int e = 0; e < 4; e++) begin
      ep_sel = 2'(e);
      #1;
      check($sformatf("R1 empty after reset ep%0d", e), {15'd0, empty_flag}, 16'd1);
      check($sformatf("R1 full after reset ep%0d", e), {15'd0, full_flag}, 16'd0);
    end

    // Table walk covering R2 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [23:0] t;
      t = VEC[k];
      op(t[23:22], t[21], t[20], t[19], {8'h00, t[18:11]});
      peek(v);
      check($sformatf("R2 R7 R8 R9 empty vector %0d", k), {15'd0, empty_flag}, {15'd0, t[10]});
      check($sformatf("R3 full vector %0d", k), {15'd0, full_flag}, {15'd0, t[9]});
      if (t[8]) check($sformatf("R5 R6 data vector %0d", k), {8'h00, v[7:0]}, {8'h00, t[7:0]});
    end

    // R4: bus released when oe or cs is low
    op(2'd0, 1'b1, 1'b0, 1'b1, 16'h005A);
    tb_en = 1'b1; tb_drv = 16'h0000; oe = 1'b0; #1;
    check("R4 released with oe low", data_io, 16'h0000);
    cs = 1'b0; oe = 1'b1; #1;
    check("R4 released with cs low", data_io, 16'h0000);
    oe = 1'b0; tb_en = 1'b0; cs = 1'b1; #1;
    peek(v);
    check("R4 driven head with oe", {8'h00, v[7:0]}, 16'h005A);

    // R11: strobes ignored while cs is low
    cs = 1'b0;
    op(2'd0, 1'b1, 1'b0, 1'b1, 16'h0077);
    op(2'd0, 1'b0, 1'b1, 1'b0, 16'h0000);
    cs = 1'b1; #1;
    peek(v);
    check("R11 head kept with cs low", {8'h00, v[7:0]}, 16'h005A);
    op(2'd0, 1'b0, 1'b1, 1'b0, 16'h0000);
    check("R11 no byte written with cs low", {15'd0, empty_flag}, 16'd1);

    // R5: read while empty dropped, pointers stay consistent
    op(2'd0, 1'b0, 1'b1, 1'b0, 16'h0000);
    check("R5 still empty after empty read", {15'd0, empty_flag}, 16'd1);
    op(2'd0, 1'b1, 1'b0, 1'b1, 16'h0033);
    peek(v);
    check("R5 head after empty read", {8'h00, v[7:0]}, 16'h0033);
    op(2'd0, 1'b0, 1'b1, 1'b0, 16'h0000);

    // R10: word mode on endpoint 3
    op(2'd3, 1'b1, 1'b0, 1'b0, 16'hBEEF);
    op(2'd3, 1'b1, 1'b0, 1'b1, 16'h1234);
    peek(v);
    check("R10 first word", v, 16'hBEEF);
    op(2'd3, 1'b0, 1'b1, 1'b0, 16'h0000);
    peek(v);
    check("R10 second word", v, 16'h1234);
    op(2'd3, 1'b0, 1'b1, 1'b0, 16'h0000);
    check("R10 empty after two words", {15'd0, empty_flag}, 16'd1);

    // R3: fill endpoint 1, overflow write dropped
    for (int i = 0; i < DEPTH; i++) op(2'd1, 1'b1, 1'b0, 1'b0, 16'(i[7:0] ^ 8'h5C));
    check("R3 full at capacity", {15'd0, full_flag}, 16'd1);
    check("R7 uncommitted hidden when full", {15'd0, empty_flag}, 16'd1);
    op(2'd1, 1'b1, 1'b0, 1'b0, 16'h00FF);
    op(2'd1, 1'b0, 1'b0, 1'b1, 16'h0000);
    check("R9 commit of full buffer", {15'd0, empty_flag}, 16'd0);
    for (int i = 0; i < DEPTH; i++) begin
      peek(v);
      check($sformatf("R3 readback byte %0d", i), {8'h00, v[7:0]}, {8'h00, i[7:0] ^ 8'h5C});
      op(2'd1, 1'b0, 1'b1, 1'b0, 16'h0000);
    end
    check("R3 empty after drain, overflow byte absent", {15'd0, empty_flag}, 16'd1);
    check("R3 not full after drain", {15'd0, full_flag}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule